// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when an 8-bit microcontroller core runs, sleeps lightly or sleeps deeply. Software raises a one-cycle idle or power-down request. The controller then gates the core clock, and in deep sleep it also stops the oscillator. It drives fixed levels onto the address-latch and program-strobe pins, and it floats the multiplexed low address/data port while code runs from external memory.

Wake-up from light sleep happens on any enabled pending interrupt or on a qualified reset. Deep sleep has two exits:

- **Reset pin.** Raising the reset pin restarts the oscillator. After the stabilization window, the pin must stay high for two machine cycles. The exit then issues a register-reset strobe.
- **External interrupt pin.** The pin must be enabled and set to level mode. Pulling it low restarts the oscillator. The exit only completes once the pin goes high again, and the registers keep their contents.

The oscillator start-up is modelled by a stabilization counter whose length is an input.

Every control and status pin is a plain level. The block has no streaming data path and no back-pressure.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in the run state: `core_clk_en`=1, `osc_en`=1, `sfr_reset`=0, and all pin overrides (`ale_ovr`, `psen_ovr`, `p0_float`) are 0.
- R2: A power-down request takes precedence over an idle request raised in the same cycle. From the clock edge that samples the request, `core_clk_en` and `osc_en` are 0.
- R3: In light sleep, `core_clk_en`=0 and `osc_en`=1, and both pin overrides are active with value 1. A sampled `irq_pending` or a qualified reset returns the block to run on the next edge.
- R4: In deep sleep, `osc_en`=0 and `core_clk_en`=0, and both pin overrides are active with value 0. The following have no effect: `irq_pending`, and a low level on an external pin that is disabled (`xint_en`=0) or in edge mode (`xint_level`=0).
- R5: `p0_float` equals `ext_exec` in every state except run, where it is 0.
- R6: An external pin that is low, enabled and level-sensitive (bit 0 is the first pin) wakes deep sleep: `osc_en` rises on the next edge while `core_clk_en` stays 0. After stabilization the block waits until no such pin is low, then returns to run without a `sfr_reset` strobe.
- R7: The stabilization window lasts max(`stab_count`,1) cycles with the oscillator enabled. The core clock stays off for the whole window.
- R8: `sfr_reset` pulses for exactly one cycle. The pulse comes after `hw_reset` has been sampled high on 2*`MC_CLKS` consecutive edges while the oscillator is stable, and it forces the run state. A shorter pulse produces no strobe.
- R9: `hw_reset` high in deep sleep restarts the oscillator. The qualification count starts only after stabilization. If `hw_reset` falls before qualification, the block returns to deep sleep.
- R10: If `hw_reset` and an external wake pin are both active in deep sleep, the reset exit is taken. Releasing the pin does not then complete the exit; only the `sfr_reset` strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous power-on reset of the controller, active low |
| hw_reset | input | 1 | External reset pin, active high, needs qualification |
| req_idle | input | 1 | Software request for light sleep |
| req_pdown | input | 1 | Software request for deep sleep |
| xint_n | input | NUM_XINT | External interrupt pins, active low |
| xint_en | input | NUM_XINT | Per-pin interrupt enable |
| xint_level | input | NUM_XINT | Per-pin mode, 1 = level-sensitive |
| irq_pending | input | 1 | Any enabled interrupt pending |
| ext_exec | input | 1 | Core is executing from external program memory |
| stab_count | input | STAB_W | Oscillator stabilization length in cycles |
| core_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| sfr_reset | output | 1 | One-cycle register-reset strobe |
| ale_ovr | output | 1 | Address-latch pin override active |
| ale_val | output | 1 | Forced address-latch pin level |
| psen_ovr | output | 1 | Program-strobe pin override active |
| psen_val | output | 1 | Forced program-strobe pin level |
| p0_float | output | 1 | Float the low address/data port |

## Verification
The checker assumes that `stab_count` and `ext_exec` do not change in the middle of a sleep or wake sequence. It also assumes that requests arrive as clean synchronous levels. The stimulus changes those inputs only while the block runs, and drives every input on the falling clock edge. A behavioural reference model predicts every output on every cycle. Directed sequences cover the following:

- request priority;
- ignored wake sources;
- the two-phase pin exit;
- a one-cycle stabilization window;
- a short reset pulse that must be ignored;
- a reset exit that is abandoned;
- a simultaneous reset and pin wake.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    PM_RUN,
    PM_IDLE,
    PM_DOWN,
    PM_RESTART,
    PM_HOLD
  } pm_state_t;

  typedef enum logic {
    WK_PIN,
    WK_RST
  } wake_src_t;
endpackage

// File: rtl/lpm_rst_qual.sv
// Counts consecutive cycles of the reset pin while the oscillator is stable.
module lpm_rst_qual #(
  parameter int HOLD_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic osc_run,
  output logic hit
);
  localparam int W = $clog2(HOLD_CYC + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!pin || !osc_run) begin
      cnt <= '0;
    end else if (cnt != W'(HOLD_CYC)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = pin && osc_run && (cnt == W'(HOLD_CYC - 1));
endmodule

// File: rtl/lpm_stab_cnt.sv
// Models oscillator start-up: done on the last cycle of the window.
module lpm_stab_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;
  logic [W:0]   nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign done = run && (nxt >= {1'b0, limit});
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_hit,
  input  logic stab_done,
  input  logic wake_pin,
  input  logic rst_pin,
  input  logic req_idle,
  input  logic req_pdown,
  input  logic irq_pending,
  input  logic ext_exec,
  output logic core_clk_en,
  output logic osc_en,
  output logic osc_run,
  output logic restarting,
  output logic ale_ovr,
  output logic ale_val,
  output logic psen_ovr,
  output logic psen_val,
  output logic p0_float
);
  pm_state_t st, st_nx;
  wake_src_t src, src_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PM_RUN;
      src <= WK_PIN;
    end else begin
      st  <= st_nx;
      src <= src_nx;
    end
  end

  always_comb begin
    st_nx  = st;
    src_nx = src;
    case (st)
      PM_RUN: begin
        if (rst_hit)        st_nx = PM_RUN;
        else if (req_pdown) st_nx = PM_DOWN;
        else if (req_idle)  st_nx = PM_IDLE;
      end
      PM_IDLE: begin
        if (rst_hit || irq_pending) st_nx = PM_RUN;
      end
      PM_DOWN: begin
        if (rst_pin) begin
          st_nx  = PM_RESTART;
          src_nx = WK_RST;
        end else if (wake_pin) begin
          st_nx  = PM_RESTART;
          src_nx = WK_PIN;
        end
      end
      PM_RESTART: begin
        if (stab_done) st_nx = PM_HOLD;
      end
      PM_HOLD: begin
        if (rst_hit) begin
          st_nx = PM_RUN;
        end else if (src == WK_RST) begin
          if (!rst_pin) st_nx = PM_DOWN;
        end else if (!wake_pin) begin
          st_nx = PM_RUN;
        end
      end
      default: st_nx = PM_RUN;
    endcase
  end

  always_comb begin
    core_clk_en = (st == PM_RUN);
    osc_en      = (st != PM_DOWN);
    osc_run     = (st == PM_RUN) || (st == PM_IDLE) || (st == PM_HOLD);
    restarting  = (st == PM_RESTART);
    ale_ovr     = (st != PM_RUN);
    ale_val     = (st == PM_IDLE);
    psen_ovr    = (st != PM_RUN);
    psen_val    = (st == PM_IDLE);
    p0_float    = (st != PM_RUN) && ext_exec;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int MC_CLKS  = 12,
  parameter int STAB_W   = 8,
  parameter int NUM_XINT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_reset,
  input  logic                req_idle,
  input  logic                req_pdown,
  input  logic [NUM_XINT-1:0] xint_n,
  input  logic [NUM_XINT-1:0] xint_en,
  input  logic [NUM_XINT-1:0] xint_level,
  input  logic                irq_pending,
  input  logic                ext_exec,
  input  logic [STAB_W-1:0]   stab_count,
  output logic                core_clk_en,
  output logic                osc_en,
  output logic                sfr_reset,
  output logic                ale_ovr,
  output logic                ale_val,
  output logic                psen_ovr,
  output logic                psen_val,
  output logic                p0_float
);
  localparam int QUAL_CYC = 2 * MC_CLKS;

  logic [NUM_XINT-1:0] pin_wake;
  logic wake_any, rst_hit, stab_done, osc_run, restarting;

  for (genvar g = 0; g < NUM_XINT; g++) begin : g_wake
    assign pin_wake[g] = ~xint_n[g] & xint_en[g] & xint_level[g];
  end
  assign wake_any = |pin_wake;

  lpm_rst_qual #(.HOLD_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin(hw_reset), .osc_run(osc_run), .hit(rst_hit)
  );

  lpm_stab_cnt #(.W(STAB_W)) u_stab (
    .clk(clk), .rst_n(rst_n), .run(restarting), .limit(stab_count), .done(stab_done)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rst_hit(rst_hit), .stab_done(stab_done),
    .wake_pin(wake_any), .rst_pin(hw_reset), .req_idle(req_idle),
    .req_pdown(req_pdown), .irq_pending(irq_pending), .ext_exec(ext_exec),
    .core_clk_en(core_clk_en), .osc_en(osc_en), .osc_run(osc_run),
    .restarting(restarting), .ale_ovr(ale_ovr), .ale_val(ale_val),
    .psen_ovr(psen_ovr), .psen_val(psen_val), .p0_float(p0_float)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sfr_reset <= 1'b0;
    else        sfr_reset <= rst_hit;
  end
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_reset,
  input logic req_pdown,
  input logic core_clk_en,
  input logic osc_en,
  input logic sfr_reset,
  input logic ale_ovr,
  input logic ale_val,
  input logic psen_ovr,
  input logic psen_val,
  input logic p0_float
);
  // R2
  pdown_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en && req_pdown && !hw_reset |=> !osc_en && !core_clk_en);

  // R3
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_ovr && ale_val |-> osc_en && !core_clk_en && psen_ovr && psen_val);

  // R4
  down_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> ale_ovr && !ale_val && psen_ovr && !psen_val && !core_clk_en);

  // R5
  run_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> !p0_float && !ale_ovr && !psen_ovr);

  // R6
  restart_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> !core_clk_en);

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_reset |=> !sfr_reset);

  // R8
  strobe_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_reset |-> core_clk_en && $past(hw_reset));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .req_pdown(req_pdown),
  .core_clk_en(core_clk_en), .osc_en(osc_en), .sfr_reset(sfr_reset),
  .ale_ovr(ale_ovr), .ale_val(ale_val), .psen_ovr(psen_ovr),
  .psen_val(psen_val), .p0_float(p0_float)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  localparam int MC = 12;
  localparam int SW = 8;
  localparam int NX = 2;
  localparam int QUAL = 2 * MC;
  localparam int M_ACT = 0, M_IDL = 1, M_PDN = 2, M_STB = 3, M_HLD = 4;

  logic clk = 1'b0, rst_n = 1'b0, hw_reset = 1'b0, req_idle = 1'b0, req_pdown = 1'b0;
  logic irq_pending = 1'b0, ext_exec = 1'b0;
  logic [NX-1:0] xint_n = '1, xint_en = '0, xint_level = '0;
  logic [SW-1:0] stab_count = 8'd5;
  logic core_clk_en, osc_en, sfr_reset, ale_ovr, ale_val, psen_ovr, psen_val, p0_float;

  always #10 clk = ~clk;

  lpm_ctrl #(.MC_CLKS(MC), .STAB_W(SW), .NUM_XINT(NX)) u_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .req_idle(req_idle),
    .req_pdown(req_pdown), .xint_n(xint_n), .xint_en(xint_en),
    .xint_level(xint_level), .irq_pending(irq_pending), .ext_exec(ext_exec),
    .stab_count(stab_count), .core_clk_en(core_clk_en), .osc_en(osc_en),
    .sfr_reset(sfr_reset), .ale_ovr(ale_ovr), .ale_val(ale_val),
    .psen_ovr(psen_ovr), .psen_val(psen_val), .p0_float(p0_float)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;

  int m = M_ACT, qcnt = 0, scnt = 0, cause_rst = 0;
  bit exp_sfr = 1'b0;

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_int(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  always @(posedge clk) begin : ref_model
    bit run, hit, wake, done;
    int lim;
    cyc++;
    if (!rst_n) begin
      m = M_ACT; qcnt = 0; scnt = 0; exp_sfr = 1'b0; cause_rst = 0;
    end else begin
      run  = (m == M_ACT) || (m == M_IDL) || (m == M_HLD);
      hit  = 1'b0;
      if (hw_reset && run) begin
        qcnt++;
        if (qcnt == QUAL) hit = 1'b1;
      end else begin
        qcnt = 0;
      end
      wake = 1'b0;
      for (int i = 0; i < NX; i++)
        if (!xint_n[i] && xint_en[i] && xint_level[i]) wake = 1'b1;
      done = 1'b0;
      if (m == M_STB) begin
        scnt++;
        lim = (stab_count == 0) ? 1 : int'(stab_count);
        done = (scnt >= lim);
      end else begin
        scnt = 0;
      end
      exp_sfr = hit;
      if (m == M_ACT) begin
        if (!hit) begin
          if (req_pdown) m = M_PDN;
          else if (req_idle) m = M_IDL;
        end
      end else if (m == M_IDL) begin
        if (hit || irq_pending) m = M_ACT;
      end else if (m == M_PDN) begin
        if (hw_reset) begin m = M_STB; cause_rst = 1; end
        else if (wake) begin m = M_STB; cause_rst = 0; end
      end else if (m == M_STB) begin
        if (done) m = M_HLD;
      end else begin
        if (hit) m = M_ACT;
        else if (cause_rst != 0) begin
          if (!hw_reset) m = M_PDN;
        end else if (!wake) m = M_ACT;
      end
    end
  end

  function automatic string st_tag(int s);
    case (s)
      M_ACT: return "R1";
      M_IDL: return "R3";
      M_PDN: return "R4";
      M_STB: return "R7";
      default: return "R6";
    endcase
  endfunction

  // Every-cycle comparison, away from the edge.
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      check(st_tag(m), "core_clk_en", core_clk_en, m == M_ACT);
      check(st_tag(m), "osc_en", osc_en, m != M_PDN);
      check(st_tag(m), "ale_ovr", ale_ovr, m != M_ACT);
      check(st_tag(m), "ale_val", ale_val, m == M_IDL);
      check(st_tag(m), "psen_ovr", psen_ovr, m != M_ACT);
      check(st_tag(m), "psen_val", psen_val, m == M_IDL);
      check("R5", "p0_float", p0_float, (m != M_ACT) && ext_exec);
      check("R8", "sfr_reset", sfr_reset, exp_sfr);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample();
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 50000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  task automatic enter_pdown();
    @(negedge clk); req_pdown = 1'b1;
    @(negedge clk); req_pdown = 1'b0;
  endtask

  initial begin
    int pulses, at;
    step(3);
    rst_n = 1'b1;
    sample();
    check("R1", "core_clk_en after reset", core_clk_en, 1'b1);
    check("R1", "osc_en after reset", osc_en, 1'b1);
    check("R1", "sfr_reset after reset", sfr_reset, 1'b0);

    // R3 light sleep and wake-up on pending interrupt
    @(negedge clk); req_idle = 1'b1;
    sample();
    check("R3", "core_clk_en in idle", core_clk_en, 1'b0);
    check("R3", "ale_val in idle", ale_val, 1'b1);
    @(negedge clk); req_idle = 1'b0;
    step(4);
    irq_pending = 1'b1;
    sample();
    check("R3", "core_clk_en after irq", core_clk_en, 1'b1);
    @(negedge clk); irq_pending = 1'b0;

    // R5 port float follows external execution in idle
    ext_exec = 1'b1;
    @(negedge clk); req_idle = 1'b1;
    sample();
    check("R5", "p0_float idle ext", p0_float, 1'b1);
    @(negedge clk); req_idle = 1'b0; irq_pending = 1'b1;
    @(negedge clk); irq_pending = 1'b0;
    ext_exec = 1'b0;

    // R2 both requests: deep sleep wins
    @(negedge clk); req_idle = 1'b1; req_pdown = 1'b1;
    sample();
    check("R2", "osc_en after dual request", osc_en, 1'b0);
    check("R2", "ale_val after dual request", ale_val, 1'b0);
    @(negedge clk); req_idle = 1'b0; req_pdown = 1'b0;

    // R4 ignored wake sources
    irq_pending = 1'b1; xint_n = 2'b00; xint_en = 2'b01; xint_level = 2'b10;
    step(6);
    sample();
    check("R4", "osc_en with ignored sources", osc_en, 1'b0);
    @(negedge clk); irq_pending = 1'b0; xint_n = 2'b11;
    xint_en = 2'b11; xint_level = 2'b11;

    // R6 two-phase pin exit
    @(negedge clk); xint_n[1] = 1'b0;
    sample();
    check("R6", "osc_en restarts", osc_en, 1'b1);
    check("R6", "core_clk_en gated", core_clk_en, 1'b0);
    step(15);
    sample();
    check("R6", "core waits for pin release", core_clk_en, 1'b0);
    @(negedge clk); xint_n[1] = 1'b1;
    sample();
    check("R6", "core runs after release", core_clk_en, 1'b1);
    check("R6", "no strobe on pin exit", sfr_reset, 1'b0);

    // R7 one-cycle window with zero count
    stab_count = 8'd0;
    enter_pdown();
    @(negedge clk); xint_n[0] = 1'b0;
    @(negedge clk); xint_n[0] = 1'b1;
    sample();
    check("R7", "hold phase after 1-cycle window", core_clk_en, 1'b0);
    sample();
    check("R7", "run after 1-cycle window", core_clk_en, 1'b1);
    stab_count = 8'd3;
    enter_pdown();
    @(negedge clk); xint_n[0] = 1'b0;
    step(6);
    xint_n[0] = 1'b1;
    step(3);
    stab_count = 8'd5;

    // R8 short pulse ignored, full pulse strobes once
    @(negedge clk); hw_reset = 1'b1;
    step(10);
    hw_reset = 1'b0;
    step(3);
    hw_reset = 1'b1;
    pulses = 0; at = 0;
    for (int k = 1; k <= QUAL + 6; k++) begin
      sample();
      if (sfr_reset) begin pulses++; at = k; end
    end
    check_int("R8", "strobe count", pulses, 1);
    check_int("R8", "strobe cycle", at, QUAL);
    @(negedge clk); hw_reset = 1'b0;

    // R9 reset in deep sleep released too early, then held
    enter_pdown();
    @(negedge clk); hw_reset = 1'b1;
    step(3);
    hw_reset = 1'b0;
    step(20);
    sample();
    check("R9", "back in deep sleep", osc_en, 1'b0);
    @(negedge clk); hw_reset = 1'b1;
    step(QUAL + 10);
    sample();
    check("R9", "run after reset exit", core_clk_en, 1'b1);
    @(negedge clk); hw_reset = 1'b0;

    // R10 reset and pin together: pin release does not end the exit
    enter_pdown();
    @(negedge clk); hw_reset = 1'b1; xint_n[0] = 1'b0;
    step(2);
    xint_n[0] = 1'b1;
    step(8);
    sample();
    check("R10", "pin release ignored under reset", core_clk_en, 1'b0);
    step(QUAL + 4);
    sample();
    check("R10", "run after reset strobe", core_clk_en, 1'b1);
    @(negedge clk); hw_reset = 1'b0;
    step(5);
    finish_run();
  end
endmodule